// File: doc/BRIEF.md
# Execute-in-Place Serial Flash Read Controller

This block lets a processor fetch code and data straight out of an external serial NOR flash. A word-read request on the memory port becomes one flash read sequence: a command byte, a 24-bit address, a set number of dummy bytes, and four data bytes. The four data bytes are packed little-endian into one 32-bit word and returned with an acknowledge. The command and the number of I/O lines used come from a configuration field. After reset the field selects the plainest form, a single-line standard read, so a reset vector held in flash can be fetched before software has set anything up.

Many flash parts need a command before they accept dual or quad reads. For this and for programming, a raw mode gives software direct byte-level access to the SPI bus through a small register port. Each byte written is exchanged full-duplex on one line, and chip select stays asserted between bytes until software releases it. The memory port accepts nothing while raw mode is on, so code that uses raw mode has to run from some other memory.

Top module: `qspi_xip_ctrl`

## Requirements
- R1: After reset, flash_cs_n is 1, flash_sck is 0, flash_io_oe is 0, mem_ack is 0, the configuration register (register address 0) reads 0x00, and the control register (address 1) reads 0x01 (ready).
- R2: With the mode field 00, a memory read sends command 0x03 on IO0, then the 24-bit address most significant bit first on IO0 with no dummy clocks, then samples 32 data bits on IO1. Data is 8 bits per byte, MSB first, and the first byte lands in mem_rdata[7:0], the next in [15:8], and so on.
- R3: With the mode field 01, a memory read sends command 0x0B. The address goes on IO0 and the data is sampled on IO1.
- R4: With the mode field 10, a memory read sends 0xBB on IO0. The address and the data then use IO1:IO0 with 2 bits per clock, the higher bit on IO1.
- R5: With the mode field 11, a memory read sends 0xEB on IO0. The address and the data then use IO3:IO0 with 4 bits per clock. The controller does not drive any IO line while the flash returns data.
- R6: The dummy field gives the number of dummy bytes (0 to 3) between the address and the data. Each dummy byte takes 8 clocks on one line, 4 clocks on two lines, or 2 clocks on four lines. The controller drives no IO line during dummy clocks.
- R7: mem_ack rises only after the last data bit has been sampled, is high for exactly one cycle, and comes with flash_cs_n already high.
- R8: A memory write request is acknowledged in the cycle after it is accepted, and it causes no flash activity.
- R9: While the raw bit is set, the memory port acknowledges neither reads nor writes, and the flash stays deselected.
- R10: Writing a byte to register address 2 in raw mode starts an 8-clock full-duplex transfer. The byte goes out MSB first on IO0 while IO1 is sampled. Once the transfer completes, the received byte reads back at register address 3.
- R11: Bit 0 of the control register reads 1 when a raw transfer can start. It reads 0 from the cycle after a raw byte is written until that transfer ends.
- R12: A raw transfer drives flash_cs_n low, and it stays low across later raw bytes. Writing 1 to bit 1 of the control register while no transfer is running sets flash_cs_n high on the next cycle.
- R13: The configuration register at address 0 holds the raw bit in bit 0, the mode field in bits 2:1 and the dummy field in bits 4:3, and it reads back what was written to those bits.
- R14: SCK idles low, and each SCK period lasts 2*SCK_HALF clock cycles. Outputs change on the falling edge and inputs are sampled on the rising edge. SCK pulses and IO drive occur only while flash_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory request, held until mem_ack |
| mem_we | input | 1 | Request is a write (acknowledged and ignored) |
| mem_addr | input | ADDR_W | Byte address of the first of four flash bytes |
| mem_rdata | output | 32 | Assembled read word |
| mem_ack | output | 1 | One-cycle completion pulse |
| reg_addr | input | 2 | Register select: 0 config, 1 control, 2 raw transmit, 3 raw receive |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| flash_sck | output | 1 | Serial clock |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_io_out | output | 4 | IO3..IO0 output values |
| flash_io_oe | output | 4 | IO3..IO0 output enables |
| flash_io_in | input | 4 | IO3..IO0 pad inputs |

## Verification
The bound checker enforces the pin-level rules on every cycle. SCK may pulse and any IO line may be driven only while chip select is low. The acknowledge lasts a single cycle, comes with chip select already released, and never appears while raw mode has the port locked out. Only the bench scenarios, which run against a behavioural flash, can show that each mode sends the right command, sends the address on the right lanes and MSB first, inserts the programmed number of dummy clocks, and packs the four data bytes little-endian. The same holds for raw byte exchange, the ready bit and deselect.

// File: rtl/qspi_xip_pkg.sv
package qspi_xip_pkg;

   typedef enum logic [1:0] {
      RD_STD  = 2'b00,
      RD_FAST = 2'b01,
      RD_DUAL = 2'b10,
      RD_QUAD = 2'b11
   } rd_mode_e;

   typedef enum logic [1:0] {
      LN_1 = 2'd0,
      LN_2 = 2'd1,
      LN_4 = 2'd2
   } lanes_e;

   localparam logic [1:0] RA_CFG  = 2'd0;
   localparam logic [1:0] RA_CTRL = 2'd1;
   localparam logic [1:0] RA_TX   = 2'd2;
   localparam logic [1:0] RA_RX   = 2'd3;

   function automatic logic [7:0] cmd_of(rd_mode_e m);
      case (m)
         RD_STD:  return 8'h03;
         RD_FAST: return 8'h0B;
         RD_DUAL: return 8'hBB;
         default: return 8'hEB;
      endcase
   endfunction

   function automatic lanes_e data_lanes(rd_mode_e m);
      case (m)
         RD_DUAL: return LN_2;
         RD_QUAD: return LN_4;
         default: return LN_1;
      endcase
   endfunction

   function automatic lanes_e addr_lanes(rd_mode_e m);
      if (m == RD_DUAL || m == RD_QUAD) return data_lanes(m);
      return LN_1;
   endfunction

endpackage

// File: rtl/qspi_byte_engine.sv
module qspi_byte_engine
   import qspi_xip_pkg::*;
#(
   parameter int SCK_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  lanes_e     lanes,
   input  logic       drive,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sck,
   output logic [3:0] io_out,
   output logic [3:0] io_oe,
   input  logic [3:0] io_in
);

   logic [7:0] tx_sr, rx_sr, rx_next, tx_next;
   logic [2:0] clk_cnt, last_cnt;
   lanes_e     lanes_q;
   logic       drive_q;
   logic       tick;

   // half-period timer: a straight pass-through when one cycle per half
   generate
      if (SCK_HALF == 1) begin : g_div_none
         assign tick = busy;
      end else begin : g_div_cnt
         localparam int DIV_W = $clog2(SCK_HALF);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || start || !busy) div_q <= '0;
            else if (div_q == DIV_W'(SCK_HALF - 1)) div_q <= '0;
            else div_q <= div_q + 1'b1;
         end
         assign tick = busy && (div_q == DIV_W'(SCK_HALF - 1));
      end
   endgenerate

   always_comb begin
      case (lanes_q)
         LN_1: begin
            last_cnt = 3'd7;
            rx_next  = {rx_sr[6:0], io_in[1]};
            tx_next  = {tx_sr[6:0], 1'b0};
            io_out   = {3'b000, tx_sr[7]};
            io_oe    = 4'b0001;
         end
         LN_2: begin
            last_cnt = 3'd3;
            rx_next  = {rx_sr[5:0], io_in[1:0]};
            tx_next  = {tx_sr[5:0], 2'b00};
            io_out   = {2'b00, tx_sr[7:6]};
            io_oe    = 4'b0011;
         end
         default: begin
            last_cnt = 3'd1;
            rx_next  = {rx_sr[3:0], io_in};
            tx_next  = {tx_sr[3:0], 4'b0000};
            io_out   = tx_sr[7:4];
            io_oe    = 4'b1111;
         end
      endcase
      if (!(busy && drive_q)) io_oe = 4'b0000;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         sck     <= 1'b0;
         tx_sr   <= '0;
         rx_sr   <= '0;
         clk_cnt <= '0;
         lanes_q <= LN_1;
         drive_q <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            sck     <= 1'b0;
            tx_sr   <= tx_byte;
            lanes_q <= lanes;
            drive_q <= drive;
            clk_cnt <= '0;
         end else if (tick) begin
            if (!sck) begin
               sck   <= 1'b1;
               rx_sr <= rx_next;
            end else begin
               sck <= 1'b0;
               if (clk_cnt == last_cnt) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  clk_cnt <= clk_cnt + 1'b1;
                  tx_sr   <= tx_next;
               end
            end
         end
      end
   end

   assign rx_byte = rx_sr;

endmodule

// File: rtl/qspi_xip_seq.sv
module qspi_xip_seq
   import qspi_xip_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int DUMMY_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_rdata,
   output logic              mem_ack,
   input  logic              raw_mode,
   input  rd_mode_e          mode,
   input  logic [DUMMY_W-1:0] dummy,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [7:0]        eng_rx,
   output logic              eng_start,
   output logic [7:0]        eng_tx,
   output lanes_e            eng_lanes,
   output logic              eng_drive,
   output logic              active
);

   localparam int ABYTES = ADDR_W / 8;
   localparam int IDX_W  = $clog2(ABYTES + (2 ** DUMMY_W) + 5);

   logic [ADDR_W-1:0]  addr_q;
   rd_mode_e           mode_q;
   logic [DUMMY_W-1:0] dummy_q;
   logic [IDX_W-1:0]   idx_q, nidx, data_first, last_idx;
   logic [1:0]         slot;
   logic               run_q, ack_q, start_q, drive_q;
   logic [7:0]         tx_q, nx_tx;
   lanes_e             lanes_q, nx_lanes;
   logic               nx_drive;
   logic [31:0]        rdata_q;

   assign data_first = IDX_W'(1 + ABYTES) + IDX_W'(dummy_q);
   assign last_idx   = data_first + IDX_W'(3);
   assign nidx       = idx_q + 1'b1;
   assign slot       = 2'(idx_q - data_first);

   // setup of the byte that follows the current one
   always_comb begin
      nx_tx    = 8'h00;
      nx_lanes = data_lanes(mode_q);
      nx_drive = 1'b0;
      if (nidx <= IDX_W'(ABYTES)) begin
         nx_tx    = 8'(addr_q >> (ADDR_W - 8 * int'(nidx)));
         nx_lanes = addr_lanes(mode_q);
         nx_drive = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ack_q   <= 1'b0;
         start_q <= 1'b0;
         idx_q   <= '0;
         addr_q  <= '0;
         mode_q  <= RD_STD;
         dummy_q <= '0;
         tx_q    <= '0;
         lanes_q <= LN_1;
         drive_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= 1'b0;
         start_q <= 1'b0;
         if (!run_q) begin
            if (mem_req && !raw_mode && !ack_q && !eng_busy) begin
               if (mem_we) begin
                  ack_q <= 1'b1;
               end else begin
                  run_q   <= 1'b1;
                  idx_q   <= '0;
                  addr_q  <= mem_addr;
                  mode_q  <= mode;
                  dummy_q <= dummy;
                  start_q <= 1'b1;
                  tx_q    <= cmd_of(mode);
                  lanes_q <= LN_1;
                  drive_q <= 1'b1;
               end
            end
         end else if (eng_done) begin
            if (idx_q >= data_first) rdata_q[8*slot +: 8] <= eng_rx;
            if (idx_q == last_idx) begin
               run_q <= 1'b0;
               ack_q <= 1'b1;
            end else begin
               idx_q   <= nidx;
               start_q <= 1'b1;
               tx_q    <= nx_tx;
               lanes_q <= nx_lanes;
               drive_q <= nx_drive;
            end
         end
      end
   end

   assign mem_ack   = ack_q;
   assign mem_rdata = rdata_q;
   assign eng_start = start_q;
   assign eng_tx    = tx_q;
   assign eng_lanes = lanes_q;
   assign eng_drive = drive_q;
   assign active    = run_q;

endmodule

// File: rtl/qspi_xip_ctrl.sv
module qspi_xip_ctrl
   import qspi_xip_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int SCK_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_rdata,
   output logic              mem_ack,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              flash_sck,
   output logic              flash_cs_n,
   output logic [3:0]        flash_io_out,
   output logic [3:0]        flash_io_oe,
   input  logic [3:0]        flash_io_in
);

   localparam int DUMMY_W = 2;

   generate
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
      if (ADDR_W % 8 != 0 || ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must be a whole number of bytes from 8 to 32");
      end
   endgenerate

   logic               cfg_raw_q;
   rd_mode_e           cfg_mode_q;
   logic [DUMMY_W-1:0] cfg_dummy_q;
   logic [7:0]         rx_q;
   logic               raw_sel_q, raw_pend_q;

   logic       eng_start, eng_busy, eng_done, eng_drive;
   logic [7:0] eng_tx, eng_rx;
   lanes_e     eng_lanes;

   logic       seq_start, seq_drive, seq_busy;
   logic [7:0] seq_tx;
   lanes_e     seq_lanes;

   logic raw_start, deselect, ready;

   assign ready     = !eng_busy && !seq_busy;
   assign raw_start = reg_wr && (reg_addr == RA_TX) && cfg_raw_q && ready;
   assign deselect  = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[1] && !eng_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_raw_q   <= 1'b0;
         cfg_mode_q  <= RD_STD;
         cfg_dummy_q <= '0;
      end else if (reg_wr && reg_addr == RA_CFG) begin
         cfg_raw_q   <= reg_wdata[0];
         cfg_mode_q  <= rd_mode_e'(reg_wdata[2:1]);
         cfg_dummy_q <= reg_wdata[4:3];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_sel_q  <= 1'b0;
         raw_pend_q <= 1'b0;
         rx_q       <= '0;
      end else begin
         if (!cfg_raw_q && !eng_busy) raw_sel_q <= 1'b0;
         else if (raw_start)          raw_sel_q <= 1'b1;
         else if (deselect)           raw_sel_q <= 1'b0;
         if (raw_start) raw_pend_q <= 1'b1;
         else if (raw_pend_q && eng_done) begin
            raw_pend_q <= 1'b0;
            rx_q       <= eng_rx;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_CFG:  reg_rdata = {3'b000, cfg_dummy_q, cfg_mode_q, cfg_raw_q};
         RA_CTRL: reg_rdata = {7'b0, ready};
         RA_RX:   reg_rdata = rx_q;
         default: reg_rdata = 8'h00;
      endcase
   end

   qspi_xip_seq #(
      .ADDR_W  (ADDR_W),
      .DUMMY_W (DUMMY_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .raw_mode  (cfg_raw_q),
      .mode      (cfg_mode_q),
      .dummy     (cfg_dummy_q),
      .eng_busy  (eng_busy),
      .eng_done  (eng_done),
      .eng_rx    (eng_rx),
      .eng_start (seq_start),
      .eng_tx    (seq_tx),
      .eng_lanes (seq_lanes),
      .eng_drive (seq_drive),
      .active    (seq_busy)
   );

   assign eng_start = seq_start | raw_start;
   assign eng_tx    = seq_busy ? seq_tx    : reg_wdata;
   assign eng_lanes = seq_busy ? seq_lanes : LN_1;
   assign eng_drive = seq_busy ? seq_drive : 1'b1;

   qspi_byte_engine #(
      .SCK_HALF (SCK_HALF)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start),
      .tx_byte (eng_tx),
      .lanes   (eng_lanes),
      .drive   (eng_drive),
      .busy    (eng_busy),
      .done    (eng_done),
      .rx_byte (eng_rx),
      .sck     (flash_sck),
      .io_out  (flash_io_out),
      .io_oe   (flash_io_oe),
      .io_in   (flash_io_in)
   );

   assign flash_cs_n = !(seq_busy || raw_sel_q);

endmodule

// File: rtl/qspi_xip_checker.sv
module qspi_xip_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sck,
   input logic [3:0] io_oe,
   input logic       mem_ack,
   input logic       raw_mode,
   input logic       seq_busy
);

   AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> !cs_n); // R14

   AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (io_oe == 4'b0000)); // R14

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |=> !mem_ack); // R7

   AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |-> (cs_n && !seq_busy)); // R7

   AST_RAW_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(raw_mode) && !$past(seq_busy)) |-> !mem_ack); // R9

endmodule

bind qspi_xip_ctrl qspi_xip_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (flash_cs_n),
   .sck      (flash_sck),
   .io_oe    (flash_io_oe),
   .mem_ack  (mem_ack),
   .raw_mode (cfg_raw_q),
   .seq_busy (seq_busy)
);

// File: tb/qspi_xip_ctrl_test.sv
module qspi_xip_ctrl_test;

   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req = 1'b0, mem_we = 1'b0;
   logic [23:0] mem_addr = '0;
   logic [31:0] mem_rdata;
   logic        mem_ack;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        sck, cs_n;
   logic [3:0]  io_out, io_oe, io_in, flash_drv;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   qspi_xip_ctrl #(.ADDR_W(24), .SCK_HALF(HALF)) uut (
      .clk(clk), .rst_n(rst_n),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .flash_sck(sck), .flash_cs_n(cs_n), .flash_io_out(io_out),
      .flash_io_oe(io_oe), .flash_io_in(io_in)
   );

   assign io_in = (io_oe & io_out) | (~io_oe & flash_drv);

   // ---------------- behavioural flash ----------------
   int          nclk = 0, m_la = 1, m_ld = 1, m_dstart = 1000, m_dummy = 0, conflict = 0;
   logic [7:0]  m_cmd = '0;
   logic [23:0] m_addr = '0;

   function automatic logic [7:0] memf(logic [23:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
   endfunction

   function automatic logic [7:0] idb(int i);
      case (i)
         0: return 8'hC2;
         1: return 8'h25;
         default: return 8'h39;
      endcase
   endfunction

   initial flash_drv = 4'b0010;

   always @(negedge cs_n) begin
      nclk = 0; m_cmd = '0; m_addr = '0; m_la = 1; m_ld = 1; m_dstart = 1000;
      flash_drv = 4'b0010;
   end

   always @(posedge sck) if (!cs_n) begin
      if (nclk < 8) begin
         m_cmd = {m_cmd[6:0], io_out[0]};
         if (nclk == 7) begin
            case (m_cmd)
               8'h03: begin m_la = 1; m_ld = 1; m_dstart = 32; end
               8'h0B: begin m_la = 1; m_ld = 1; m_dstart = 32 + 8 * m_dummy; end
               8'hBB: begin m_la = 2; m_ld = 2; m_dstart = 20 + 4 * m_dummy; end
               8'hEB: begin m_la = 4; m_ld = 4; m_dstart = 14 + 2 * m_dummy; end
               8'h9F: begin m_la = 1; m_ld = 1; m_dstart = 8; end
               default: m_dstart = 1000;
            endcase
         end
      end else if (m_cmd != 8'h9F && nclk < 8 + 24 / m_la) begin
         case (m_la)
            1: m_addr = {m_addr[22:0], io_out[0]};
            2: m_addr = {m_addr[21:0], io_out[1:0]};
            default: m_addr = {m_addr[19:0], io_out};
         endcase
      end
      if (nclk >= m_dstart && io_oe != 4'b0000) conflict++;
      nclk++;
   end

   always @(negedge sck) if (!cs_n) begin
      if (nclk >= m_dstart) begin
         int b, cpb, bi, ch;
         logic [7:0] byt, bits;
         b = nclk - m_dstart; cpb = 8 / m_ld; bi = b / cpb; ch = b % cpb;
         byt = (m_cmd == 8'h9F) ? idb(bi) : memf(m_addr + 24'(bi));
         bits = (byt >> (8 - m_ld * (ch + 1))) & 8'((1 << m_ld) - 1);
         case (m_ld)
            1: flash_drv = {2'b00, bits[0], 1'b0};
            2: flash_drv = {2'b00, bits[1:0]};
            default: flash_drv = bits[3:0];
         endcase
      end else flash_drv = 4'b0010;
   end

   // ---------------- helpers ----------------
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_ready();
      logic [7:0] c;
      do reg_read(2'd1, c); while (c[0] !== 1'b1);
   endtask

   task automatic mem_read(input logic [23:0] a, output logic [31:0] w, output logic csh);
      @(negedge clk);
      mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
      do @(negedge clk); while (mem_ack !== 1'b1);
      w = mem_rdata; csh = cs_n;
      mem_req = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic test_reset();
      logic [7:0] d;
      check("R1 cs_n", 32'(cs_n), 32'd1);
      check("R1 sck", 32'(sck), 32'd0);
      check("R1 io_oe", 32'(io_oe), 32'd0);
      check("R1 mem_ack", 32'(mem_ack), 32'd0);
      reg_read(2'd0, d); check("R1 config", 32'(d), 32'h00);
      reg_read(2'd1, d); check("R1 control", 32'(d), 32'h01);
   endtask

   task automatic test_read(input string tag, input logic [7:0] cfg, input int dmy,
                            input logic [23:0] a, input logic [7:0] cmd, input int total);
      logic [31:0] w, exp;
      logic csh;
      logic [7:0] d;
      m_dummy = dmy;
      conflict = 0;
      reg_write(2'd0, cfg);
      reg_read(2'd0, d); check({tag, " R13 config readback"}, 32'(d), 32'(cfg));
      mem_read(a, w, csh);
      exp = {memf(a + 24'd3), memf(a + 24'd2), memf(a + 24'd1), memf(a)};
      check({tag, " command"}, 32'(m_cmd), 32'(cmd));
      check({tag, " address"}, 32'(m_addr), 32'(a));
      check({tag, " word"}, w, exp);
      check({tag, " R6 R7 clocks at ack"}, 32'(nclk), 32'(total));
      check({tag, " R7 cs high at ack"}, 32'(csh), 32'd1);
      check({tag, " R5 R6 no drive in data"}, 32'(conflict), 32'd0);
      @(negedge clk);
      check({tag, " R7 ack one cycle"}, 32'(mem_ack), 32'd0);
   endtask

   task automatic test_write();
      int cyc = 0;
      int lows = 0;
      int n0;
      n0 = nclk;
      @(negedge clk);
      mem_req = 1'b1; mem_we = 1'b1; mem_addr = 24'h000040;
      do begin
         @(negedge clk); cyc++;
         if (!cs_n) lows++;
      end while (mem_ack !== 1'b1 && cyc < 20);
      mem_req = 1'b0; mem_we = 1'b0;
      check("R8 write ack latency", 32'(cyc), 32'd1);
      check("R8 no select", 32'(lows), 32'd0);
      check("R8 no clocks", 32'(nclk), 32'(n0));
   endtask

   task automatic test_raw();
      logic [7:0] d;
      int acks = 0, lows = 0;
      realtime t1, t2;
      reg_write(2'd0, 8'h01);
      reg_read(2'd0, d); check("R13 raw bit", 32'(d), 32'h01);
      reg_read(2'd1, d); check("R11 ready idle", 32'(d[0]), 32'd1);
      @(negedge clk);
      mem_req = 1'b1; mem_we = 1'b0; mem_addr = 24'h000100;
      repeat (100) begin
         @(negedge clk);
         if (mem_ack) acks++;
         if (!cs_n) lows++;
      end
      mem_we = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (mem_ack) acks++;
      end
      mem_req = 1'b0; mem_we = 1'b0;
      check("R9 no ack in raw", 32'(acks), 32'd0);
      check("R9 flash idle", 32'(lows), 32'd0);

      reg_write(2'd2, 8'h9F);
      #1 check("R11 ready busy", 32'(reg_rdata[0] & (reg_addr == 2'd1)), 32'd0);
      reg_read(2'd1, d); check("R11 ready low in transfer", 32'(d[0]), 32'd0);
      @(posedge sck); t1 = $realtime;
      @(posedge sck); t2 = $realtime;
      check("R14 sck period", 32'(int'((t2 - t1) / 20.0)), 32'(2 * HALF));
      wait_ready();
      check("R10 command seen", 32'(m_cmd), 32'h9F);
      check("R10 clocks", 32'(nclk), 32'd8);
      reg_read(2'd3, d); check("R10 rx first", 32'(d), 32'hFF);
      check("R12 cs held", 32'(cs_n), 32'd0);
      reg_write(2'd2, 8'h00); wait_ready();
      reg_read(2'd3, d); check("R10 rx second", 32'(d), 32'hC2);
      reg_write(2'd2, 8'h00); wait_ready();
      reg_read(2'd3, d); check("R10 rx third", 32'(d), 32'h25);
      check("R12 cs still held", 32'(cs_n), 32'd0);
      reg_write(2'd1, 8'h02);
      check("R12 deselect", 32'(cs_n), 32'd1);
      reg_write(2'd0, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();                                                        // R1
      test_read("R2", 8'h00, 0, 24'h000100, 8'h03, 64);                    // R2
      test_read("R3", 8'h0A, 1, 24'h12345C, 8'h0B, 72);                    // R3
      test_read("R4", 8'h0C, 1, 24'hABCDE0, 8'hBB, 40);                    // R4
      test_read("R5", 8'h1E, 3, 24'hFFFFF8, 8'hEB, 28);                    // R5
      test_read("R6", 8'h14, 2, 24'h5A5A00, 8'hBB, 44);                    // R6
      reg_write(2'd0, 8'h00);
      test_write();                                                        // R8
      test_raw();                                                          // R9 R10 R11 R12 R14
      test_read("R2 after raw", 8'h00, 0, 24'h000204, 8'h03, 64);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule